// File: doc/BRIEF.md
# Framed Serial Word Receiver with CRC Check

This block sits directly behind a 16-bit deserializer, in the receive clock domain. On every cycle it takes one 16-bit word and a 2-bit control-character indication. Payload words are gathered three at a time into 48-bit words. Each 48-bit word goes to a downstream FIFO with a one-cycle write strobe.

A frame closes with two trailer words. The first trailer is a control word that carries a fixed code. The word that follows it holds the CRC the sender expects. A CRC engine runs over every payload word and over the first trailer, but not over the second. The block compares its result with the received value and gives a one-cycle verdict. That verdict also updates three saturating statistics counters and a sticky error flag.

Sequencing only starts when the first payload word arrives. It is forced back to idle whenever the receiver loses frequency or PLL lock, or when the synchronous soft reset is high.

Top module: `frame_rx_checker`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, every output is zero.
- R2: When no frame is open, control words (any nonzero `rx_ctrl_i`) are ignored, including the trailer code. The first word with `rx_ctrl_i == 0` opens a frame and is its first payload word.
- R3: Payload words are packed in arrival order, the first into `word_o[47:32]` and the third into `word_o[15:0]`. `word_wr_o` is high for exactly the one cycle after the third word is sampled, and low otherwise. Control words inside a frame neither break nor extend a group.
- R4: Inside a frame, a trailer is a word with `rx_ctrl_i != 0` and `rx_data_i == TRAILER` (default 16'hF7F7). Any other control word inside a frame is ignored.
- R5: The CRC is CRC-16 with polynomial 0x1021, initial value 0xFFFF, processed MSB first with no reflection and no final XOR. It covers all payload words plus the first trailer. `crc_calc_o` shows the result from the verdict cycle onward.
- R6: The word sampled right after the first trailer is the second trailer, whatever its control bits. All 16 of its bits are the expected CRC. In the cycle after it is sampled, `crc_valid_o` is 1 for one cycle only. `crc_bad_o` is 1 in that cycle if the values differ, and 0 if they match.
- R7: The total, good and error counters count verdicts and saturate at all ones. Total is always good plus error, and once total saturates, none of the three changes.
- R8: `err_flag_o` goes high at the first mismatch verdict and stays high until `rst_ni`.
- R9: `hit_count_o` gives the number of 48-bit words written during the last completed frame. A partial group left at frame end is dropped.
- R10: Low `freq_lock_i` or `pll_lock_i`, or high `soft_rst_i`, aborts any open frame. It discards the partial group and returns the block to idle with no verdict and no write. Counters and flag are kept.
- R11: A new frame may begin in the cycle right after a second trailer. It starts from a fresh CRC and an empty group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_data_i | input | 16 | Word from the deserializer |
| rx_ctrl_i | input | 2 | Control-character indication, nonzero for a control word |
| freq_lock_i | input | 1 | Receiver frequency lock |
| pll_lock_i | input | 1 | Receiver PLL lock |
| soft_rst_i | input | 1 | Synchronous sequencing reset, active high |
| word_o | output | 48 | Packed payload word |
| word_wr_o | output | 1 | FIFO write strobe for `word_o` |
| hit_count_o | output | 12 | 48-bit words written in the last completed frame |
| crc_calc_o | output | 16 | CRC computed over the last completed frame |
| crc_bad_o | output | 1 | Mismatch indication, valid with `crc_valid_o` |
| crc_valid_o | output | 1 | One-cycle verdict strobe |
| frames_total_o | output | 32 | Frames judged |
| frames_err_o | output | 32 | Frames with CRC mismatch |
| frames_good_o | output | 32 | Frames with CRC match |
| err_flag_o | output | 1 | Sticky mismatch flag |

## Verification
Some properties are checked on every cycle:
- the counter identity (total equals good plus error) and the one-step counter increments;
- the single-cycle shape of both strobes;
- that a mismatch always comes with the valid strobe;
- that the error flag is sticky;
- that a cycle with lock lost or soft reset is never followed by a verdict or a write.

Other behaviour only shows up in the bench's frame scenarios:
- the CRC values themselves and the packing order;
- that control words are ignored when idle and inside a frame;
- that a partial group is dropped and the per-frame word count is correct;
- saturation, frames sent back to back, and clean recovery after an abort at several points in a frame.

// File: rtl/frx_pkg.sv
package frx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_TAIL = 2'd2
  } frx_state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  // one 16-bit word, MSB first
  function automatic logic [15:0] crc16_word(input logic [15:0] crc, input logic [15:0] data);
    logic [15:0] c;
    logic        fb;
    c = crc;
    for (int i = 15; i >= 0; i--) begin
      fb = c[15] ^ data[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/frx_crc16.sv
module frx_crc16 import frx_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [15:0] data_i,
  output logic [15:0] crc_o
);

  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_INIT;
    else if (clr_i)   crc_q <= CRC_INIT;
    else if (en_i)    crc_q <= crc16_word(crc_q, data_i);
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/frx_packer.sv
module frx_packer #(
  parameter int WORD_W = 16,
  parameter int LANES  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    push_i,
  input  logic [WORD_W-1:0]       data_i,
  output logic [LANES*WORD_W-1:0] word_o,
  output logic                    wr_o,
  output logic                    emit_o
);

  localparam int HOLD_W = (LANES - 1) * WORD_W;
  localparam int IDX_W  = (LANES > 2) ? $clog2(LANES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic [HOLD_W-1:0]       hold_q;
  logic [IDX_W-1:0]        idx_q;
  logic [LANES*WORD_W-1:0] word_q;
  logic                    wr_q;

  assign emit_o = push_i && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      idx_q  <= '0;
      word_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      wr_q <= emit_o;
      if (clr_i) begin
        idx_q <= '0;
      end else if (push_i) begin
        if (emit_o) begin
          word_q <= {hold_q, data_i};
          idx_q  <= '0;
        end else begin
          hold_q <= (hold_q << WORD_W) | HOLD_W'(data_i);
          idx_q  <= idx_q + 1'b1;
        end
      end
    end
  end

  assign word_o = word_q;
  assign wr_o   = wr_q;

endmodule

// File: rtl/frx_stats.sv
module frx_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             verdict_i,
  input  logic             bad_i,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] good_o,
  output logic [CNT_W-1:0] err_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] total_q, good_q, err_q;
  logic             flag_q;
  logic             at_max;

  assign at_max = (total_q == '1);

  // total gates both halves so total == good + err always
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q <= '0;
      good_q  <= '0;
      err_q   <= '0;
      flag_q  <= 1'b0;
    end else if (verdict_i) begin
      if (bad_i) flag_q <= 1'b1;
      if (!at_max) begin
        total_q <= total_q + 1'b1;
        if (bad_i) err_q  <= err_q + 1'b1;
        else       good_q <= good_q + 1'b1;
      end
    end
  end

  assign total_o = total_q;
  assign good_o  = good_q;
  assign err_o   = err_q;
  assign flag_o  = flag_q;

endmodule

// File: rtl/frame_rx_checker.sv
module frame_rx_checker import frx_pkg::*; #(
  parameter int          DATA_W  = 16,
  parameter int          CTRL_W  = 2,
  parameter int          LANES   = 3,
  parameter int          HIT_W   = 12,
  parameter int          CNT_W   = 32,
  parameter logic [15:0] TRAILER = 16'hF7F7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DATA_W-1:0]       rx_data_i,
  input  logic [CTRL_W-1:0]       rx_ctrl_i,
  input  logic                    freq_lock_i,
  input  logic                    pll_lock_i,
  input  logic                    soft_rst_i,
  output logic [LANES*DATA_W-1:0] word_o,
  output logic                    word_wr_o,
  output logic [HIT_W-1:0]        hit_count_o,
  output logic [15:0]             crc_calc_o,
  output logic                    crc_bad_o,
  output logic                    crc_valid_o,
  output logic [CNT_W-1:0]        frames_total_o,
  output logic [CNT_W-1:0]        frames_err_o,
  output logic [CNT_W-1:0]        frames_good_o,
  output logic                    err_flag_o
);

  frx_state_e      state_q, state_d;
  logic            clr, is_data, is_trl;
  logic            take, trl_hit, done, mismatch;
  logic            emit;
  logic [15:0]     crc_val;
  logic [HIT_W-1:0] frame_words_q;
  logic [15:0]     crc_calc_q;
  logic [HIT_W-1:0] hit_q;
  logic            valid_q, bad_q;

  assign clr      = soft_rst_i | ~freq_lock_i | ~pll_lock_i;
  assign is_data  = (rx_ctrl_i == '0);
  assign is_trl   = (rx_ctrl_i != '0) && (rx_data_i == TRAILER);
  assign mismatch = (rx_data_i != crc_val);

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    trl_hit = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (is_data) begin
        take    = 1'b1;
        state_d = ST_BODY;
      end
      ST_BODY: begin
        if (is_data) take = 1'b1;
        else if (is_trl) begin
          trl_hit = 1'b1;
          state_d = ST_TAIL;
        end
      end
      ST_TAIL: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (clr) begin
      take    = 1'b0;
      trl_hit = 1'b0;
      done    = 1'b0;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  frx_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr | done),
    .en_i   (take | trl_hit),
    .data_i (rx_data_i),
    .crc_o  (crc_val)
  );

  frx_packer #(.WORD_W(DATA_W), .LANES(LANES)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr | done),
    .push_i (take),
    .data_i (rx_data_i),
    .word_o (word_o),
    .wr_o   (word_wr_o),
    .emit_o (emit)
  );

  frx_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .verdict_i (done),
    .bad_i     (mismatch),
    .total_o   (frames_total_o),
    .good_o    (frames_good_o),
    .err_o     (frames_err_o),
    .flag_o    (err_flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_words_q <= '0;
      crc_calc_q    <= '0;
      hit_q         <= '0;
      valid_q       <= 1'b0;
      bad_q         <= 1'b0;
    end else begin
      valid_q <= done;
      bad_q   <= done & mismatch;
      if (done) begin
        crc_calc_q <= crc_val;
        hit_q      <= frame_words_q;
      end
      if (clr || done)                       frame_words_q <= '0;
      else if (emit && frame_words_q != '1)  frame_words_q <= frame_words_q + 1'b1;
    end
  end

  assign crc_calc_o  = crc_calc_q;
  assign hit_count_o = hit_q;
  assign crc_valid_o = valid_q;
  assign crc_bad_o   = bad_q;

endmodule

// File: rtl/frame_rx_checker_sva.sv
module frame_rx_checker_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             freq_lock_i,
  input logic             pll_lock_i,
  input logic             soft_rst_i,
  input logic             word_wr_o,
  input logic             crc_bad_o,
  input logic             crc_valid_o,
  input logic [CNT_W-1:0] frames_total_o,
  input logic [CNT_W-1:0] frames_err_o,
  input logic [CNT_W-1:0] frames_good_o,
  input logic             err_flag_o
);

  a_r3_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_wr_o |=> !word_wr_o);

  a_r6_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_valid_o |=> !crc_valid_o);

  a_r6_bad_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_bad_o |-> crc_valid_o);

  a_r7_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, frames_total_o} == ({1'b0, frames_good_o} + {1'b0, frames_err_o})));

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_valid_o && $past(frames_total_o) != '1) |->
      (frames_total_o == $past(frames_total_o) + CNT_W'(1)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crc_valid_o |-> $stable(frames_total_o));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag_o |=> err_flag_o);

  a_r8_set_on_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_bad_o |-> err_flag_o);

  a_r10_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freq_lock_i || !pll_lock_i || soft_rst_i) |=> (!crc_valid_o && !word_wr_o));

endmodule

bind frame_rx_checker frame_rx_checker_sva #(.CNT_W(CNT_W)) u_sva (.*);

// File: tb/frame_rx_checker_tb.sv
`timescale 1ns/1ps
module frame_rx_checker_tb;

  localparam int          CW  = 4;
  localparam logic [15:0] TRL = 16'hF7F7;
  localparam int          MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rx_data = '0;
  logic [1:0]  rx_ctrl = 2'b01;
  logic        freq_lock = 1'b1, pll_lock = 1'b1, soft_rst = 1'b0;
  logic [47:0] word;
  logic        word_wr, crc_bad, crc_valid, err_flag;
  logic [11:0] hit_count;
  logic [15:0] crc_calc;
  logic [CW-1:0] tot_o, err_o, good_o;

  int errs = 0, checks = 0;
  int m_tot = 0, m_good = 0, m_err = 0;
  bit m_flag = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frame_rx_checker #(.CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_ctrl_i(rx_ctrl),
    .freq_lock_i(freq_lock), .pll_lock_i(pll_lock), .soft_rst_i(soft_rst),
    .word_o(word), .word_wr_o(word_wr), .hit_count_o(hit_count),
    .crc_calc_o(crc_calc), .crc_bad_o(crc_bad), .crc_valid_o(crc_valid),
    .frames_total_o(tot_o), .frames_err_o(err_o), .frames_good_o(good_o),
    .err_flag_o(err_flag)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int b = 15; b >= 0; b--) begin
      if (r[15] != d[b]) r = (r << 1) ^ 16'h1021;
      else               r = r << 1;
    end
    return r;
  endfunction

  task automatic put(input logic [1:0] c, input logic [15:0] d);
    @(negedge clk);
    rx_ctrl = c;
    rx_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_stats(input string req);
    chk(req, "total", 64'(tot_o), 64'(m_tot));
    chk(req, "good", 64'(good_o), 64'(m_good));
    chk(req, "err", 64'(err_o), 64'(m_err));
    chk("R8", "flag", 64'(err_flag), 64'(m_flag));
  endtask

  task automatic run_frame(input int n, input bit corrupt, input bit gaps, input int seed);
    logic [15:0] crc = 16'hFFFF;
    logic [47:0] grp = '0;
    int k = 0, emits = 0;
    for (int i = 0; i < n; i++) begin
      logic [15:0] d = 16'(seed * 16'h0731 + i * 16'h1357 + 16'h00A5);
      put(2'b00, d);
      if (i == 0) chk("R6", "valid one cycle", 64'(crc_valid), 64'd0);
      crc = ref_crc(crc, d);
      grp = {grp[31:0], d};
      k++;
      if (k == 3) begin
        chk("R3", "wr", 64'(word_wr), 64'd1);
        chk("R3", "word", 64'(word), 64'(grp));
        k = 0;
        emits++;
      end else begin
        chk("R3", "no wr", 64'(word_wr), 64'd0);
      end
      if (gaps && (i % 2 == 0)) begin
        put(2'b10, 16'h1C1C);  // R4: non-trailer control word inside frame
        chk("R4", "gap no wr", 64'(word_wr), 64'd0);
      end
    end
    put(2'b01, TRL);
    crc = ref_crc(crc, TRL);
    chk("R6", "no early verdict", 64'(crc_valid), 64'd0);
    put(2'b11, corrupt ? (crc ^ 16'h0100) : crc);
    chk("R6", "valid", 64'(crc_valid), 64'd1);
    chk("R6", "bad", 64'(crc_bad), 64'(corrupt));
    chk("R5", "crc", 64'(crc_calc), 64'(crc));
    chk("R9", "hits", 64'(hit_count), 64'(emits));
    if (m_tot < MAXC) begin
      m_tot++;
      if (corrupt) m_err++; else m_good++;
    end
    if (corrupt) m_flag = 1;
    chk_stats("R7");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "word", 64'(word), 64'd0);
    chk("R1", "wr", 64'(word_wr), 64'd0);
    chk("R1", "valid", 64'(crc_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "valid", 64'(crc_valid), 64'd0);
    chk("R1", "bad", 64'(crc_bad), 64'd0);
    chk("R1", "crc", 64'(crc_calc), 64'd0);
    chk("R1", "hits", 64'(hit_count), 64'd0);
    chk_stats("R1");

    // R2: idle control words, incl. trailer code, are ignored
    put(2'b01, TRL);
    put(2'b10, 16'h1234);
    put(2'b11, TRL);
    chk("R2", "idle valid", 64'(crc_valid), 64'd0);
    chk("R2", "idle wr", 64'(word_wr), 64'd0);
    chk_stats("R2");

    // R11: sweep of lengths, back to back
    for (int n = 1; n <= 10; n++) run_frame(n, (n % 4 == 0), n[0], n);

    // R10: abort mid-group via PLL lock loss
    for (int i = 0; i < 4; i++) put(2'b00, 16'(16'hAA00 + i));
    pll_lock = 1'b0;
    put(2'b01, 16'h00BC);
    chk("R10", "pll abort wr", 64'(word_wr), 64'd0);
    pll_lock = 1'b1;
    put(2'b01, TRL);
    put(2'b11, 16'h0000);
    chk("R10", "pll abort valid", 64'(crc_valid), 64'd0);
    chk_stats("R10");
    run_frame(3, 0, 0, 77);

    // R10: abort on the second trailer via frequency lock loss
    for (int i = 0; i < 3; i++) put(2'b00, 16'(16'h5500 + i));
    put(2'b01, TRL);
    freq_lock = 1'b0;
    put(2'b01, 16'h0000);
    freq_lock = 1'b1;
    put(2'b01, 16'h00BC);
    chk("R10", "freq abort valid", 64'(crc_valid), 64'd0);
    chk_stats("R10");
    run_frame(5, 1, 1, 91);

    // R10: soft reset mid-frame
    for (int i = 0; i < 2; i++) put(2'b00, 16'(16'h3300 + i));
    soft_rst = 1'b1;
    put(2'b00, 16'h3302);
    chk("R10", "soft abort wr", 64'(word_wr), 64'd0);
    soft_rst = 1'b0;
    put(2'b01, 16'h00BC);
    chk_stats("R10");
    run_frame(6, 0, 0, 12);

    // R7: drive past saturation
    for (int f = 0; f < 6; f++) run_frame(2 + f, f[0], 0, 200 + f);
    chk("R7", "saturated total", 64'(tot_o), 64'(MAXC));

    put(2'b01, 16'h00BC);
    chk("R6", "valid one cycle", 64'(crc_valid), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule